// File: doc/BRIEF.md
# Per-Queue Wide-Word Write Aggregator

This block sits in front of a slow, wide packet memory. Narrow data chunks come in one at a time, each tagged with a queue number and a byte count. The block appends each chunk to a tail buffer that belongs to that queue. When a buffer holds one full wide word, the block issues a single write toward the memory. The write carries the queue number and the packed word. No wide write ever holds bytes from two queues, even when packets of any length arrive from many queues mixed together. The wide memory takes one write per long access period, so each write must be as full as possible.

Bytes are packed in arrival order from byte 0 upward. A chunk that does not fit in the space left spills its remaining bytes into the start of the same queue's next word, in the same cycle. A per-queue flush pushes out a partly filled buffer with its true byte count. Both the chunk input and the word output are valid/ready streams. A beat moves when valid and ready are both high at a rising clock edge. While valid is high and ready is low, the source must hold the beat unchanged. The output holds its word unchanged until it is taken. The block never drops data. When the output register is full and not being drained, or when a flush is waiting, the input ready goes low.

Top module: `qtail_packer`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and every tail buffer is empty, so flushing any queue produces no output word.
- R2: Chunk byte u is in_data[8u+7:8u]. Word byte k is out_data[8k+7:8k]. A queue's accepted bytes fill its word from byte 0 upward, in the order they arrive.
- R3: The chunk that brings a queue's buffer to WORD_BYTES bytes makes out_valid high one clock later, with out_len = WORD_BYTES and out_qid equal to that queue.
- R4: Chunks from different queues may interleave in any order. Every output word holds bytes of only the queue named by out_qid.
- R5: When a chunk overflows the space left in its queue's buffer, the extra bytes become bytes 0 and up of that queue's next word. No byte is lost or repeated.
- R6: in_len gives the number of valid low bytes of in_data, from 1 to UNIT_BYTES. A chunk with in_len = 0 is accepted and changes nothing.
- R7: While out_valid is high and out_ready is low, out_valid, out_qid, out_len and out_data stay unchanged and in_ready is 0.
- R8: A one-cycle pulse on flush[q] emits queue q's partial word with out_len equal to the bytes held, byte positions at or above out_len set to 0, and then empties the buffer. Flushing an empty queue emits nothing.
- R9: While any flush request is waiting, in_ready is 0. Waiting flushes are served one per cycle when the output is free, lowest queue number first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Chunk beat present |
| in_ready | output | 1 | Block accepts a chunk this cycle |
| in_qid | input | $clog2(NUM_Q) | Queue the chunk belongs to |
| in_data | input | UNIT_BYTES*8 | Chunk bytes, byte 0 in the low bits |
| in_len | input | $clog2(UNIT_BYTES+1) | Valid byte count of the chunk |
| flush | input | NUM_Q | Per-queue flush request pulse |
| out_valid | output | 1 | Wide write present |
| out_ready | input | 1 | Memory side takes the write |
| out_qid | output | $clog2(NUM_Q) | Queue of the wide word |
| out_data | output | WORD_BYTES*8 | Packed wide word, byte 0 in the low bits |
| out_len | output | $clog2(WORD_BYTES+1) | Valid bytes in out_data |

## Verification
The hardest case to reach is a chunk that crosses a word boundary and then a flush of the spilled remainder. To find that remainder, the bench must control exactly how many bytes each queue holds. The stimulus sends odd-length chunks (three bytes into a 32-byte word) with a zero-length chunk in the middle, so the eleventh chunk splits across the boundary. A flush then shows the one spilled byte at position 0. Back-pressure is reached by holding out_ready low while a word completes. Flush ordering is reached by raising two flush bits in the same cycle while both queues hold partial data.

// File: rtl/qtp_pkg.sv
`timescale 1ns/1ps
package qtp_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/qtp_merge.sv
`timescale 1ns/1ps
module qtp_merge #(
  parameter int unsigned UNIT_BYTES = 4,
  parameter int unsigned WORD_BYTES = 32,
  localparam int unsigned FW = $clog2(WORD_BYTES + 1),
  localparam int unsigned LW = $clog2(UNIT_BYTES + 1)
) (
  input  logic [WORD_BYTES*8-1:0] old_tail,
  input  logic [FW-1:0]           old_fill,
  input  logic [UNIT_BYTES*8-1:0] chunk,
  input  logic [LW-1:0]           clen,
  output logic [WORD_BYTES*8-1:0] full_word,
  output logic [WORD_BYTES*8-1:0] next_tail,
  output logic [FW-1:0]           next_fill,
  output logic                    done
);
  import qtp_pkg::*;

  logic [WORD_BYTES*8-1:0] spill;

  // Append chunk bytes after the current fill; bytes past the word end wrap into spill.
  always_comb begin
    int f;
    int l;
    int tot;
    f = int'(old_fill);
    l = int'(clen);
    tot = f + l;
    done = (tot >= int'(WORD_BYTES));
    full_word = old_tail;
    spill = '0;
    for (int p = 0; p < int'(WORD_BYTES); p++) begin
      for (int u = 0; u < int'(UNIT_BYTES); u++) begin
        if (u < l && p == f + u)
          full_word[p*BYTE_W +: BYTE_W] = chunk[u*BYTE_W +: BYTE_W];
        if (u < l && p + int'(WORD_BYTES) == f + u)
          spill[p*BYTE_W +: BYTE_W] = chunk[u*BYTE_W +: BYTE_W];
      end
    end
    next_tail = done ? spill : full_word;
    next_fill = done ? FW'(tot - int'(WORD_BYTES)) : FW'(tot);
  end
endmodule

// File: rtl/qtp_tail_store.sv
`timescale 1ns/1ps
module qtp_tail_store #(
  parameter int unsigned NUM_Q      = 4,
  parameter int unsigned WORD_BYTES = 32,
  localparam int unsigned QW = $clog2(NUM_Q),
  localparam int unsigned FW = $clog2(WORD_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [QW-1:0]           wr_q,
  input  logic [WORD_BYTES*8-1:0] wr_tail,
  input  logic [FW-1:0]           wr_fill,
  input  logic [QW-1:0]           a_q,
  output logic [WORD_BYTES*8-1:0] a_tail,
  output logic [FW-1:0]           a_fill,
  input  logic [QW-1:0]           b_q,
  output logic [WORD_BYTES*8-1:0] b_tail,
  output logic [FW-1:0]           b_fill
);
  logic [WORD_BYTES*8-1:0] tail_r [NUM_Q];
  logic [FW-1:0]           fill_r [NUM_Q];

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tail_r[g] <= '0;
        fill_r[g] <= '0;
      end else if (wr_en && wr_q == QW'(g)) begin
        tail_r[g] <= wr_tail;
        fill_r[g] <= wr_fill;
      end
    end
  end

  assign a_tail = tail_r[a_q];
  assign a_fill = fill_r[a_q];
  assign b_tail = tail_r[b_q];
  assign b_fill = fill_r[b_q];
endmodule

// File: rtl/qtp_flush_arb.sv
`timescale 1ns/1ps
module qtp_flush_arb #(
  parameter int unsigned NUM_Q = 4,
  localparam int unsigned QW = $clog2(NUM_Q)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_Q-1:0] flush_in,
  input  logic             go,
  output logic [NUM_Q-1:0] pend,
  output logic             any_pend,
  output logic [QW-1:0]    sel_q
);
  logic [NUM_Q-1:0] pend_r;
  logic [NUM_Q-1:0] clr_mask;

  // Lowest-numbered waiting queue wins.
  always_comb begin
    sel_q = '0;
    for (int i = int'(NUM_Q) - 1; i >= 0; i--)
      if (pend_r[i]) sel_q = QW'(i);
  end

  assign clr_mask = go ? (NUM_Q'(1) << sel_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_r <= '0;
    else        pend_r <= (pend_r & ~clr_mask) | flush_in;
  end

  assign pend     = pend_r;
  assign any_pend = |pend_r;
endmodule

// File: rtl/qtp_out_slot.sv
`timescale 1ns/1ps
module qtp_out_slot #(
  parameter int unsigned NUM_Q      = 4,
  parameter int unsigned WORD_BYTES = 32,
  localparam int unsigned QW = $clog2(NUM_Q),
  localparam int unsigned FW = $clog2(WORD_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [QW-1:0]           ld_qid,
  input  logic [WORD_BYTES*8-1:0] ld_data,
  input  logic [FW-1:0]           ld_len,
  output logic                    free,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [QW-1:0]           out_qid,
  output logic [WORD_BYTES*8-1:0] out_data,
  output logic [FW-1:0]           out_len
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_qid   <= '0;
      out_data  <= '0;
      out_len   <= '0;
    end else if (free) begin
      out_valid <= load;
      if (load) begin
        out_qid  <= ld_qid;
        out_data <= ld_data;
        out_len  <= ld_len;
      end
    end
  end
endmodule

// File: rtl/qtail_packer.sv
`timescale 1ns/1ps
module qtail_packer #(
  parameter int unsigned NUM_Q      = 4,
  parameter int unsigned UNIT_BYTES = 4,
  parameter int unsigned WORD_UNITS = 8,
  localparam int unsigned WORD_BYTES = UNIT_BYTES * WORD_UNITS,
  localparam int unsigned QW = $clog2(NUM_Q),
  localparam int unsigned LW = $clog2(UNIT_BYTES + 1),
  localparam int unsigned FW = $clog2(WORD_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [QW-1:0]           in_qid,
  input  logic [UNIT_BYTES*8-1:0] in_data,
  input  logic [LW-1:0]           in_len,
  input  logic [NUM_Q-1:0]        flush,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [QW-1:0]           out_qid,
  output logic [WORD_BYTES*8-1:0] out_data,
  output logic [FW-1:0]           out_len
);
  logic                    slot_free;
  logic [NUM_Q-1:0]        flush_pend;
  logic                    any_pend;
  logic [QW-1:0]           fl_q;
  logic                    flush_go;
  logic                    accept;
  logic [LW-1:0]           eff_len;
  logic [WORD_BYTES*8-1:0] a_tail, b_tail, full_word, next_tail;
  logic [FW-1:0]           a_fill, b_fill, next_fill;
  logic                    done;
  logic                    wr_en;
  logic [QW-1:0]           wr_q;
  logic [WORD_BYTES*8-1:0] wr_tail;
  logic [FW-1:0]           wr_fill;
  logic                    load;
  logic [QW-1:0]           ld_qid;
  logic [WORD_BYTES*8-1:0] ld_data;
  logic [FW-1:0]           ld_len;

  // Flushes take the cycle ahead of chunks; both need a free output slot.
  assign flush_go = any_pend && slot_free;
  assign in_ready = slot_free && !any_pend;
  assign accept   = in_valid && in_ready;
  assign eff_len  = (in_len > LW'(UNIT_BYTES)) ? LW'(UNIT_BYTES) : in_len;

  qtp_flush_arb #(.NUM_Q(NUM_Q)) u_arb (
    .clk(clk), .rst_n(rst_n), .flush_in(flush), .go(flush_go),
    .pend(flush_pend), .any_pend(any_pend), .sel_q(fl_q)
  );

  qtp_tail_store #(.NUM_Q(NUM_Q), .WORD_BYTES(WORD_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_q(wr_q), .wr_tail(wr_tail), .wr_fill(wr_fill),
    .a_q(in_qid), .a_tail(a_tail), .a_fill(a_fill),
    .b_q(fl_q), .b_tail(b_tail), .b_fill(b_fill)
  );

  qtp_merge #(.UNIT_BYTES(UNIT_BYTES), .WORD_BYTES(WORD_BYTES)) u_merge (
    .old_tail(a_tail), .old_fill(a_fill), .chunk(in_data), .clen(eff_len),
    .full_word(full_word), .next_tail(next_tail), .next_fill(next_fill), .done(done)
  );

  always_comb begin
    wr_en   = accept || flush_go;
    wr_q    = flush_go ? fl_q : in_qid;
    wr_tail = flush_go ? '0 : next_tail;
    wr_fill = flush_go ? '0 : next_fill;
    load    = (accept && done) || (flush_go && b_fill != '0);
    ld_qid  = flush_go ? fl_q : in_qid;
    ld_data = flush_go ? b_tail : full_word;
    ld_len  = flush_go ? b_fill : FW'(WORD_BYTES);
  end

  qtp_out_slot #(.NUM_Q(NUM_Q), .WORD_BYTES(WORD_BYTES)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_qid(ld_qid),
    .ld_data(ld_data), .ld_len(ld_len), .free(slot_free),
    .out_valid(out_valid), .out_ready(out_ready), .out_qid(out_qid),
    .out_data(out_data), .out_len(out_len)
  );
endmodule

// File: rtl/qtp_check.sv
`timescale 1ns/1ps
module qtp_check #(
  parameter int unsigned NUM_Q      = 4,
  parameter int unsigned WORD_BYTES = 32,
  localparam int unsigned QW = $clog2(NUM_Q),
  localparam int unsigned FW = $clog2(WORD_BYTES + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [QW-1:0]           out_qid,
  input logic [WORD_BYTES*8-1:0] out_data,
  input logic [FW-1:0]           out_len,
  input logic [NUM_Q-1:0]        flush_pend
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_len) && $stable(out_qid));

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_len_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len != '0) && (out_len <= FW'(WORD_BYTES)));

  assert_flush_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|flush_pend) |-> !in_ready);

  assert_no_accept_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> (!out_valid || out_ready));

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_pad
    assert_pad_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (out_len <= FW'(b)) |-> out_data[b*8 +: 8] == 8'h00);
  end
endmodule

bind qtail_packer qtp_check #(.NUM_Q(NUM_Q), .WORD_BYTES(WORD_BYTES)) u_qtp_check (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_qid(out_qid),
  .out_data(out_data), .out_len(out_len), .flush_pend(flush_pend)
);

// File: tb/test_qtail_packer.sv
`timescale 1ns/1ps
module test_qtail_packer;
  localparam int NQ = 4;
  localparam int UB = 4;
  localparam int WB = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_qid = '0;
  logic [UB*8-1:0] in_data = '0;
  logic [2:0] in_len = '0;
  logic [NQ-1:0] flush = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [1:0] out_qid;
  logic [WB*8-1:0] out_data;
  logic [5:0] out_len;

  always #5 clk = ~clk;

  qtail_packer #(.NUM_Q(NQ), .UNIT_BYTES(UB), .WORD_UNITS(8)) i_qtail_packer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_qid(in_qid), .in_data(in_data), .in_len(in_len), .flush(flush),
    .out_valid(out_valid), .out_ready(out_ready), .out_qid(out_qid),
    .out_data(out_data), .out_len(out_len)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Reference model: per-queue byte lists, built from the requirements.
  logic [7:0] mb [NQ][WB];
  int mf [NQ];
  logic [1:0]      exp_q   [64];
  int              exp_len [64];
  logic [WB*8-1:0] exp_d   [64];
  int n_exp = 0;
  logic [1:0]      cap_q   [64];
  int              cap_len [64];
  logic [WB*8-1:0] cap_d   [64];
  int n_cap = 0;
  int seed = 1;

  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready && n_cap < 64) begin
      cap_q[n_cap]   = out_qid;
      cap_len[n_cap] = int'(out_len);
      cap_d[n_cap]   = out_data;
      n_cap = n_cap + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [WB*8-1:0] act, input logic [WB*8-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input int q, input int len);
    logic [WB*8-1:0] w = '0;
    for (int k = 0; k < len; k++) w[k*8 +: 8] = mb[q][k];
    exp_q[n_exp] = 2'(q); exp_len[n_exp] = len; exp_d[n_exp] = w;
    n_exp++;
    for (int k = 0; k < WB; k++) mb[q][k] = 8'h00;
    mf[q] = 0;
  endtask

  task automatic send(input int q, input int len);
    logic [UB*8-1:0] d;
    for (int u = 0; u < UB; u++) begin
      d[u*8 +: 8] = 8'(seed * 7 + u * 13 + q * 64);
    end
    seed++;
    @(negedge clk);
    in_valid = 1'b1; in_qid = 2'(q); in_data = d; in_len = 3'(len);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    for (int u = 0; u < len; u++) begin
      mb[q][mf[q]] = d[u*8 +: 8];
      mf[q]++;
      if (mf[q] == WB) push_exp(q, WB);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_flush(input logic [NQ-1:0] mask, input bit chk_block);
    @(negedge clk);
    flush = mask;
    @(negedge clk);
    flush = '0;
    if (chk_block) chk(in_ready == 1'b0, "R9", "in_ready while flush waits", WB*8'(in_ready), '0);
    for (int q = 0; q < NQ; q++)
      if (mask[q] && mf[q] > 0) push_exp(q, mf[q]);
  endtask

  task automatic compare_all(input string req);
    out_ready = 1'b1;
    repeat (12) @(negedge clk);
    chk(n_cap == n_exp, req, "word count", WB*8'(n_cap), WB*8'(n_exp));
    for (int i = 0; i < n_exp && i < n_cap; i++) begin
      chk(cap_q[i] == exp_q[i], req, "out_qid", WB*8'(cap_q[i]), WB*8'(exp_q[i]));
      chk(cap_len[i] == exp_len[i], req, "out_len", WB*8'(cap_len[i]), WB*8'(exp_len[i]));
      chk(cap_d[i] == exp_d[i], req, "out_data", cap_d[i], exp_d[i]);
    end
    n_cap = 0; n_exp = 0;
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1", "out_valid after reset", WB*8'(out_valid), '0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", WB*8'(in_ready), 1);
    pulse_flush(4'hF, 1'b1);
    compare_all("R1");
  endtask

  task automatic t_full_word();
    for (int i = 0; i < 8; i++) send(0, 4);
    chk(out_valid == 1'b1, "R3", "out_valid one clock after last chunk", WB*8'(out_valid), 1);
    compare_all("R2");
  endtask

  task automatic t_interleave();
    for (int i = 0; i < 8; i++)
      for (int q = 0; q < NQ; q++) send((q + i) % NQ, 4);
    compare_all("R4");
  endtask

  task automatic t_varlen_spill();
    for (int i = 0; i < 5; i++) send(2, 3);
    send(2, 0);
    repeat (3) @(negedge clk);
    chk(n_cap == 0, "R6", "no word after zero-length chunk", WB*8'(n_cap), '0);
    for (int i = 0; i < 6; i++) send(2, 3);
    compare_all("R5");
    pulse_flush(4'b0100, 1'b1);
    compare_all("R8");
  endtask

  task automatic t_backpressure();
    logic [WB*8-1:0] held;
    @(negedge clk);
    out_ready = 1'b0;
    for (int i = 0; i < 8; i++) send(1, 4);
    held = out_data;
    chk(out_valid == 1'b1, "R7", "word waiting", WB*8'(out_valid), 1);
    chk(in_ready == 1'b0, "R7", "in_ready while output blocked", WB*8'(in_ready), '0);
    repeat (4) @(negedge clk);
    chk(out_data == held && out_valid, "R7", "held word stable", out_data, held);
    chk(in_ready == 1'b0, "R7", "in_ready still low", WB*8'(in_ready), '0);
    compare_all("R7");
  endtask

  task automatic t_flush_order();
    send(3, 4); send(3, 2);
    send(1, 3);
    pulse_flush(4'b1010, 1'b1);
    compare_all("R9");
    pulse_flush(4'b0001, 1'b1);
    compare_all("R8");
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    for (int q = 0; q < NQ; q++) begin
      mf[q] = 0;
      for (int k = 0; k < WB; k++) mb[q][k] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_word();
    t_interleave();
    t_varlen_spill();
    t_backpressure();
    t_flush_order();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule